// File: doc/BRIEF.md
# Transmit Checksum Inserter

The block finishes a transport-layer checksum that the host has only partly prepared. A frame enters one byte per transfer over a valid/ready stream. With the first byte come three sideband values: the offset where checksum coverage begins, the offset of the 16-bit checksum field, and a per-frame enable. The host has already put the folded one's-complement sum of the pseudo-header into the checksum field. The block does not parse any network header.

The whole frame is stored in an internal buffer. While bytes arrive, the block adds up every byte from the coverage offset to the end of the frame as big-endian 16-bit words. The seed in the field is part of that range, so it is included in the sum. When the last byte has been taken, the complement of the folded sum replaces the field and the frame is sent out on a second valid/ready stream. While a frame is draining, the input is held off.

Top module: `tx_csum_inserter`

## Requirements
- R1: After reset, in_ready_o is 1 and out_valid_o is 0.
- R2: With the enable set, the output frame carries ~S in the field: the high byte at the field offset and the low byte at field offset + 1. Each of the two bytes is written only if its position is inside the frame. S is the 16-bit one's-complement sum, with end-around carry, of the words built from the input bytes from the coverage offset to the last byte. A byte at an even distance from the coverage offset is the high byte of its word. The field must lie at an even distance from the coverage offset.
- R3: Bytes before the coverage offset have no effect on the inserted value.
- R4: When the covered region has an odd length, its final byte forms a word with a zero low byte.
- R5: When the field lies fully inside the covered region, the output region's one's-complement sum plus the original seed folds to 0xFFFF (or 0x0000).
- R6: With the enable clear, the output frame equals the input frame byte for byte.
- R7: The output frame has the same length as the input frame. Every byte except the two field bytes is unchanged, and out_last_o is 1 only on the final byte.
- R8: out_valid_o stays 0 until the last input byte is accepted and is 1 in the next cycle. in_ready_o is 0 from that cycle until the last output byte is accepted, and is 1 in the cycle after.
- R9: While out_valid_o is 1 and out_ready_i is 0, out_valid_o, out_data_o and out_last_o hold in the next cycle.
- R10: The sideband inputs are sampled only with the first byte of a frame. Their values on later bytes have no effect.
- R11: Frames of any length from 1 up to BUF_BYTES are handled, including exactly BUF_BYTES.
- R12: A one-byte frame with field and coverage offsets 0 comes out as the complement of that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input byte valid |
| in_ready_o | output | 1 | Block can accept an input byte |
| in_data_i | input | 8 | Input byte |
| in_last_i | input | 1 | Marks the final byte of the frame |
| in_cov_off_i | input | OFF_W | Coverage start offset, sampled with the first byte |
| in_fld_off_i | input | OFF_W | Checksum field offset, sampled with the first byte |
| in_ins_en_i | input | 1 | Insertion enable, sampled with the first byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Downstream accepts the output byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Marks the final output byte |

## Verification
The first output byte is due in the cycle right after the posedge that accepts the last input byte. in_ready_o is due back in the cycle after the posedge that accepts the last output byte. The bench drives and samples only at the falling edge, so each of these checks reads the value one edge after its cause. A stalled output byte is compared one falling edge later against the value it held. Expected checksum bytes come from an arithmetic fold of the stored stimulus. The bench runs a sweep over every frame length of a 64-byte configuration, with several coverage offsets per length.

// File: rtl/csum_pkg.sv
package csum_pkg;
  typedef enum logic {ST_RECV = 1'b0, ST_DRAIN = 1'b1} cs_state_e;

  // one's-complement add with end-around carry
  function automatic logic [15:0] oc_add16(input logic [15:0] a, input logic [15:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[15:0] + {15'd0, s[16]};
  endfunction
endpackage

// File: rtl/csum_accum.sv
module csum_accum (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        clr_i,
  input  logic        en_i,
  input  logic        hi_i,
  input  logic [7:0]  byte_i,
  output logic [15:0] acc_o
);
  import csum_pkg::*;

  logic [15:0] acc_q;
  logic [15:0] word;
  logic [15:0] base;

  assign word = hi_i ? {byte_i, 8'h00} : {8'h00, byte_i};
  assign base = clr_i ? 16'h0000 : acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (en_i)  acc_q <= oc_add16(base, word);
    else if (clr_i) acc_q <= '0;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/frame_buf.sv
module frame_buf #(
  parameter int DEPTH = 2048,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [7:0]    rd_data_o
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = mem[rd_addr_i];
endmodule

// File: rtl/csum_drain.sv
module csum_drain #(
  parameter int AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] last_idx_i,
  input  logic [AW-1:0] fld_i,
  input  logic          patch_en_i,
  input  logic [15:0]   csum_i,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [7:0]    out_data_o,
  output logic          out_last_o,
  output logic          done_o
);
  logic          active_q;
  logic [AW-1:0] rd_cnt_q;
  logic          fire;
  logic          at_end;
  logic          hit_hi;
  logic          hit_lo;

  assign fire   = active_q && out_ready_i;
  assign at_end = (rd_cnt_q == last_idx_i);
  assign done_o = fire && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      rd_cnt_q <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      rd_cnt_q <= '0;
    end else if (fire) begin
      if (at_end) active_q <= 1'b0;
      else        rd_cnt_q <= rd_cnt_q + 1'b1;
    end
  end

  assign hit_hi = patch_en_i && (rd_cnt_q == fld_i);
  assign hit_lo = patch_en_i && ({1'b0, rd_cnt_q} == ({1'b0, fld_i} + (AW+1)'(1)));

  assign rd_addr_o   = rd_cnt_q;
  assign out_valid_o = active_q;
  assign out_last_o  = active_q && at_end;
  assign out_data_o  = hit_hi ? csum_i[15:8] : (hit_lo ? csum_i[7:0] : rd_data_i);

  assert_stall_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o) && $stable(out_last_o));

  assert_last_ends_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && out_last_o |=> !out_valid_o);
endmodule

// File: rtl/tx_csum_inserter.sv
module tx_csum_inserter #(
  parameter int BUF_BYTES = 2048,
  localparam int OFF_W = $clog2(BUF_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_data_i,
  input  logic             in_last_i,
  input  logic [OFF_W-1:0] in_cov_off_i,
  input  logic [OFF_W-1:0] in_fld_off_i,
  input  logic             in_ins_en_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [7:0]       out_data_o,
  output logic             out_last_o
);
  import csum_pkg::*;

  localparam logic [OFF_W-1:0] TOP_ADDR = OFF_W'(BUF_BYTES - 1);

  cs_state_e        state_q;
  logic             first_q;
  logic [OFF_W-1:0] wr_cnt_q;
  logic [OFF_W-1:0] cov_q, fld_q, last_idx_q;
  logic             en_q;
  logic             accept;
  logic [OFF_W-1:0] eff_cov;
  logic             in_region;
  logic             hi_byte;
  logic [15:0]      acc;
  logic [OFF_W-1:0] rd_addr;
  logic [7:0]       rd_data;
  logic             drain_done;

  assign in_ready_o = (state_q == ST_RECV);
  assign accept     = in_valid_i && in_ready_o;
  assign eff_cov    = first_q ? in_cov_off_i : cov_q;
  assign in_region  = (wr_cnt_q >= eff_cov);
  assign hi_byte    = ~(wr_cnt_q[0] ^ eff_cov[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_RECV;
      first_q    <= 1'b1;
      wr_cnt_q   <= '0;
      cov_q      <= '0;
      fld_q      <= '0;
      en_q       <= 1'b0;
      last_idx_q <= '0;
    end else begin
      if (accept) begin
        if (first_q) begin
          cov_q <= in_cov_off_i;
          fld_q <= in_fld_off_i;
          en_q  <= in_ins_en_i;
        end
        if (in_last_i) begin
          last_idx_q <= wr_cnt_q;
          wr_cnt_q   <= '0;
          first_q    <= 1'b1;
          state_q    <= ST_DRAIN;
        end else begin
          wr_cnt_q <= wr_cnt_q + 1'b1;
          first_q  <= 1'b0;
        end
      end
      if (state_q == ST_DRAIN && drain_done) state_q <= ST_RECV;
    end
  end

  csum_accum u_accum (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (accept && first_q),
    .en_i   (accept && in_region),
    .hi_i   (hi_byte),
    .byte_i (in_data_i),
    .acc_o  (acc)
  );

  frame_buf #(.DEPTH(BUF_BYTES)) u_buf (
    .clk_i     (clk_i),
    .wr_en_i   (accept),
    .wr_addr_i (wr_cnt_q),
    .wr_data_i (in_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  csum_drain #(.AW(OFF_W)) u_drain (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (accept && in_last_i),
    .last_idx_i  (last_idx_q),
    .fld_i       (fld_q),
    .patch_en_i  (en_q),
    .csum_i      (~acc),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (rd_data),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .done_o      (drain_done)
  );

  assert_no_overflow_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !in_last_i |-> wr_cnt_q != TOP_ADDR);

  assert_out_after_last_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> $past(in_valid_i && in_ready_o && in_last_i));

  assert_no_ingress_in_drain_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
endmodule

// File: tb/tb_tx_csum_inserter.sv
module tb_tx_csum_inserter;
  localparam int DEPTH = 64;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_last = 1'b0, in_en = 1'b0;
  logic [7:0]    in_data = '0;
  logic [AW-1:0] in_cov = '0, in_fld = '0;
  logic          in_ready;
  logic          out_valid, out_last;
  logic          out_ready = 1'b0;
  logic [7:0]    out_data;

  always #4 clk = ~clk;

  tx_csum_inserter #(.BUF_BYTES(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_data_i(in_data), .in_last_i(in_last),
    .in_cov_off_i(in_cov), .in_fld_off_i(in_fld), .in_ins_en_i(in_en),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_data_o(out_data), .out_last_o(out_last)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] frm [DEPTH];
  logic [7:0] exp_b [DEPTH];
  logic [7:0] got [DEPTH];
  int flen, fcov, ffld;
  bit fen;
  bit stall_mode;
  string tag_ovr = "";
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] rnd8();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[7:0];
  endfunction

  // arithmetic fold of a byte region, big-endian pairs from cov
  function automatic int fold_sum(input logic [7:0] b [DEPTH], input int cov, input int len);
    int s = 0;
    for (int i = cov; i < len; i++)
      s += ((i - cov) % 2 == 0) ? int'(b[i]) * 256 : int'(b[i]);
    while (s > 16'hFFFF) s = (s & 16'hFFFF) + (s >> 16);
    return s;
  endfunction

  function automatic string tag_for(input int i);
    if (tag_ovr != "") return tag_ovr;
    if (flen == 1) return "R12";
    if (!fen) return "R6";
    if (i == ffld || i == ffld + 1) return ((flen - fcov) % 2 == 1) ? "R4" : "R2";
    if (flen == DEPTH) return "R11";
    return "R7";
  endfunction

  task automatic run_frame();
    int cs;
    int idx;
    bit held;
    logic [7:0] held_d;
    logic held_l;
    for (int i = 0; i < flen; i++) exp_b[i] = frm[i];
    if (fen) begin
      cs = (~fold_sum(frm, fcov, flen)) & 16'hFFFF;
      if (ffld < flen) exp_b[ffld] = cs[15:8];
      if (ffld + 1 < flen) exp_b[ffld + 1] = cs[7:0];
    end
    for (int i = 0; i < flen; i++) begin
      @(negedge clk);
      if (((i * 7 + flen) % 5) == 0) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_data  = frm[i];
      in_last  = (i == flen - 1);
      if (i == 0) begin
        in_cov = AW'(fcov); in_fld = AW'(ffld); in_en = fen;
      end else begin  // scrambled sidebands, must be ignored (R10)
        in_cov = ~AW'(fcov); in_fld = AW'(ffld + 3); in_en = ~fen;
      end
      #1;
      chk(out_valid == 1'b0, "R8 early", out_valid, 0);
    end
    @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    #1;
    chk(out_valid == 1'b1, "R8 out due", out_valid, 1);
    chk(in_ready == 1'b0, "R8 ingress held", in_ready, 0);
    idx = 0; held = 1'b0; held_d = '0; held_l = 1'b0;
    while (idx < flen) begin
      out_ready = stall_mode ? rnd8()[0] : 1'b1;
      #1;
      if (held) begin
        chk(out_valid && out_data == held_d && out_last == held_l, "R9", out_data, held_d);
        held = 1'b0;
      end
      if (out_valid && out_ready) begin
        got[idx] = out_data;
        chk(out_data == exp_b[idx], tag_for(idx), out_data, exp_b[idx]);
        chk(out_last == (idx == flen - 1), "R7 last", out_last, idx == flen - 1);
        idx++;
      end else if (out_valid) begin
        held = 1'b1; held_d = out_data; held_l = out_last;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    #1;
    chk(out_valid == 1'b0, "R8 drain end", out_valid, 0);
    chk(in_ready == 1'b1, "R8 ingress back", in_ready, 1);
    if (fen && ffld >= fcov && ffld + 1 < flen) begin
      int r;
      r = fold_sum(got, fcov, flen) + int'({frm[ffld], frm[ffld + 1]});
      while (r > 16'hFFFF) r = (r & 16'hFFFF) + (r >> 16);
      chk(r == 16'hFFFF || r == 0, "R5", r, 16'hFFFF);
    end
  endtask

  task automatic fill_frame(input int len, input int cov, input bit en);
    int rem;
    flen = len; fcov = cov; fen = en;
    rem = len - cov;
    ffld = (rem >= 2) ? cov + 2 * ((rem / 2) / 2) : cov;
    for (int i = 0; i < len; i++) frm[i] = rnd8();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(in_ready == 1'b1, "R1 ready", in_ready, 1);
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    rst_n = 1'b1;

    // R3: pre-coverage bytes changed, checksum unchanged
    begin
      logic [7:0] c0, c1;
      stall_mode = 1'b0;
      fill_frame(20, 6, 1'b1);
      run_frame();
      c0 = got[ffld]; c1 = got[ffld + 1];
      for (int i = 0; i < 6; i++) frm[i] = ~frm[i] + 8'd3;
      run_frame();
      chk(got[ffld] == c0 && got[ffld + 1] == c1, "R3", {got[ffld], got[ffld + 1]}, {c0, c1});
    end

    // R10 explicit: later-byte sidebands scrambled inside run_frame
    tag_ovr = "R10";
    fill_frame(10, 2, 1'b1);
    run_frame();
    tag_ovr = "";

    // sweep every length, several coverage offsets
    for (int len = 1; len <= DEPTH; len++) begin
      int covs [4];
      covs[0] = 0; covs[1] = 1; covs[2] = 3; covs[3] = len - 1;
      for (int k = 0; k < 4; k++) begin
        if (covs[k] < len && !(k == 3 && covs[k] <= 3 && len > 1)) begin
          stall_mode = (k % 2 == 1);
          fill_frame(len, covs[k], 1'b1);
          run_frame();
        end
      end
      if (len % 4 == 1) begin
        stall_mode = 1'b1;
        fill_frame(len, 0, 1'b0);
        run_frame();
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule